// File: doc/BRIEF.md
# Multi-Mode Up/Down Tally Counter

This block is a 24-bit up/down counter for encoder and pulse-counting datapaths. Each cycle with `countStb` high is one count step, and `countUp` gives its direction. The counter keeps a preset register and an output latch. It can count in plain binary or as six packed decimal digits. It supports four boundary behaviours: free-running, range-limited, single-pass (non-recycling) and modulo-N. Each accepted step can raise a carry, borrow or compare event.

The events feed four status bits: three toggle bits and a sign bit. The status also carries an error bit, the last direction and the index level. Two real-time flag pins show one of four selectable signal pairs. Host commands can clear the counter, load it from the preset, or copy it into the latch. A qualified index level can trigger the same actions: on its rising edge it either loads or latches, or it either clears the counter or gates the count steps.

All state is held in flip-flops with an asynchronous active-low reset. Outputs change at the clock edge that samples the request.

Top module: `tally_counter`

## Requirements
- R1: With `bcdMode`=1, each 4-bit nibble of the count is a decimal digit, the maximum is 999999, and stepping up from 999999 gives 0 with a carry event. With `bcdMode`=0 the maximum is FFFFFF.
- R2: With `bndMode`=0 (free-running), an up step from the maximum wraps to 0 with a carry event. A down step from 0 wraps to the maximum with a borrow event. All other steps move by one.
- R3: With `bndMode`=1 (range-limited), an up step while count equals preset leaves the count unchanged, and a down step at 0 leaves it unchanged. Neither raises an event, so counting resumes only in the reverse direction.
- R4: With `bndMode`=2 (single-pass), the wrapping step behaves as in R2, and after it the counter ignores every step until a clear or a load.
- R5: With `bndMode`=3 (modulo-N), an up step at count equal to preset gives 0 with a carry event. A down step at 0 reloads the preset with a borrow event.
- R6: A compare event fires when an accepted step leaves the count equal to the preset.
- R7: The `statusFlags` bits are as follows. Bit 0 toggles on borrow, bit 1 toggles on carry and bit 2 toggles on compare. Bit 3 (sign) is set by borrow and cleared by carry. Bit 4 (error) is set by `errEvent` and cleared by `cmdClrErr`, and a set wins. Bit 5 holds the `countUp` value of the last cycle with `countStb` high. Bit 6 is `idxActive` registered. `cmdClrFlags` zeroes bits 0 to 3 and overrides events in the same cycle.
- R8: Events are one-cycle pulses in the cycle after the step. The pins follow `flagSel`: 0 gives `flg1`=carry and `flg2`=borrow; 1 gives compare and borrow; 2 gives carry-or-borrow and status bit 5; 3 gives status bit 6 and status bit 4.
- R9: `cmdClear` zeroes the count, `cmdLoad` copies the preset into it, and `cmdLatch` copies the pre-edge count into `latchVal`. Clear beats load, and either one discards a step in the same cycle. A load in the same cycle as `presetWr` uses the old preset.
- R10: A rising index edge is `idxActive`=1 while status bit 6 is 0. With `idxRouteReset`=0 it latches the count (`idxLoadLatch`=1) or loads the preset (`idxLoadLatch`=0). With `idxRouteReset`=1 and `idxResetGate`=0 it clears the count. With both set, steps count only while `idxActive` is high.
- R11: After reset the count, preset, latch, status and both flag pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countStb | input | 1 | One count step this cycle |
| countUp | input | 1 | Step direction, 1 = up |
| bcdMode | input | 1 | 1 = decimal digits, 0 = binary |
| bndMode | input | 2 | Boundary behaviour (R2 to R5) |
| flagSel | input | 2 | Flag pin pairing (R8) |
| idxActive | input | 1 | Qualified index level |
| idxRouteReset | input | 1 | Index drives the reset path (1) or the load path (0) |
| idxLoadLatch | input | 1 | Load path action: 1 latch, 0 load preset |
| idxResetGate | input | 1 | Reset path action: 1 gate steps, 0 clear |
| presetWr | input | 1 | Write `presetIn` into the preset |
| presetIn | input | 24 | New preset value |
| cmdLoad | input | 1 | Load count from preset |
| cmdClear | input | 1 | Clear count |
| cmdLatch | input | 1 | Copy count to latch |
| cmdClrFlags | input | 1 | Zero status bits 0 to 3 |
| cmdClrErr | input | 1 | Zero status bit 4 |
| errEvent | input | 1 | Set status bit 4 |
| countVal | output | 24 | Live count |
| latchVal | output | 24 | Output latch |
| statusFlags | output | 7 | Status bits (R7) |
| flg1 | output | 1 | First flag pin |
| flg2 | output | 1 | Second flag pin |

## Verification
The assertions assume that all inputs are synchronous to `clk`. In decimal mode they assume that the count and preset hold only valid digits, which requires the counter to be cleared whenever the representation changes. The stimulus switches `bcdMode` and `bndMode` only at phase starts, together with a clear and a preset write. Decimal presets are drawn from valid digit values only. The index is held low through reset, so no spurious rising edge is seen at release.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int STATUS_W = 7;

  typedef enum logic [1:0] {
    BND_FREE    = 2'd0,
    BND_RANGE   = 2'd1,
    BND_ONESHOT = 2'd2,
    BND_MODN    = 2'd3
  } bound_e;

  // one-hot-ish request strobes from control to datapath
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doLatch;
    logic doStep;
    logic stepUp;
    logic dirWr;
    logic clrFlags;
    logic clrErr;
    logic setErr;
  } strobe_t;
endpackage

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    countStb,
  input  logic    countUp,
  input  logic    idxActive,
  input  logic    idxRouteReset,
  input  logic    idxLoadLatch,
  input  logic    idxResetGate,
  input  logic    cmdLoad,
  input  logic    cmdClear,
  input  logic    cmdLatch,
  input  logic    cmdClrFlags,
  input  logic    cmdClrErr,
  input  logic    errEvent,
  output strobe_t stb,
  output logic    idxSeen
);
  logic idxPrev;
  logic idxRise;
  logic idxLoadEv;
  logic idxLatchEv;
  logic idxClrEv;
  logic gateOpen;
  logic clearReq;
  logic loadReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxPrev <= 1'b0;
    else       idxPrev <= idxActive;
  end

  assign idxRise    = idxActive & ~idxPrev;
  assign idxLoadEv  = idxRise & ~idxRouteReset & ~idxLoadLatch;
  assign idxLatchEv = idxRise & ~idxRouteReset &  idxLoadLatch;
  assign idxClrEv   = idxRise &  idxRouteReset & ~idxResetGate;
  assign gateOpen   = ~(idxRouteReset & idxResetGate) | idxActive;

  // clear beats load, both beat a count step
  assign clearReq = cmdClear | idxClrEv;
  assign loadReq  = (cmdLoad | idxLoadEv) & ~clearReq;

  always_comb begin
    stb.doClear  = clearReq;
    stb.doLoad   = loadReq;
    stb.doLatch  = cmdLatch | idxLatchEv;
    stb.doStep   = countStb & gateOpen & ~clearReq & ~loadReq;
    stb.stepUp   = countUp;
    stb.dirWr    = countStb;
    stb.clrFlags = cmdClrFlags;
    stb.clrErr   = cmdClrErr;
    stb.setErr   = errEvent;
  end

  assign idxSeen = idxPrev;
endmodule

// File: rtl/tally_datapath.sv
module tally_datapath
  import tally_pkg::*;
#(
  parameter int DIGITS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                bcdMode,
  input  logic [1:0]          bndMode,
  input  logic [1:0]          flagSel,
  input  logic                presetWr,
  input  logic [4*DIGITS-1:0] presetIn,
  input  logic                idxSeen,
  output logic [4*DIGITS-1:0] countVal,
  output logic [4*DIGITS-1:0] latchVal,
  output logic [STATUS_W-1:0] statusFlags,
  output logic                flg1,
  output logic                flg2
);
  localparam int W = 4 * DIGITS;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] BIN_MAX = {W{1'b1}};

  function automatic logic [W-1:0] allNines();
    logic [W-1:0] r;
    for (int i = 0; i < DIGITS; i++) r[4*i +: 4] = 4'd9;
    return r;
  endfunction
  localparam logic [W-1:0] BCD_MAX = allNines();

  // decimal ripple step, one digit borrows/carries into the next
  function automatic logic [W-1:0] bcdStep(input logic [W-1:0] v, input logic up);
    logic [W-1:0] r;
    logic c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (c) begin
        if (up) begin
          if (v[4*i +: 4] == 4'd9) r[4*i +: 4] = 4'd0;
          else begin r[4*i +: 4] = v[4*i +: 4] + 4'd1; c = 1'b0; end
        end else begin
          if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
          else begin r[4*i +: 4] = v[4*i +: 4] - 4'd1; c = 1'b0; end
        end
      end
    end
    return r;
  endfunction

  bound_e mode;
  logic [W-1:0] cntQ, cntD, presetQ, latchQ, maxVal, stepVal;
  logic haltQ, haltD;
  logic atMax, atZero, atPre;
  logic carry, borrow, moved, cmpHit;
  logic evCarry, evBorrow, evCmp;
  logic btQ, ctQ, cptQ, signQ, errQ, dirQ;

  assign mode    = bound_e'(bndMode);
  assign maxVal  = bcdMode ? BCD_MAX : BIN_MAX;
  assign stepVal = bcdMode ? bcdStep(cntQ, stb.stepUp)
                           : (stb.stepUp ? cntQ + ONE : cntQ - ONE);
  assign atMax   = (cntQ == maxVal);
  assign atZero  = (cntQ == '0);
  assign atPre   = (cntQ == presetQ);

  always_comb begin
    cntD   = cntQ;
    haltD  = haltQ;
    carry  = 1'b0;
    borrow = 1'b0;
    moved  = 1'b0;
    if (stb.doClear) begin
      cntD  = '0;
      haltD = 1'b0;
    end else if (stb.doLoad) begin
      cntD  = presetQ;
      haltD = 1'b0;
    end else if (stb.doStep && !haltQ) begin
      if (stb.stepUp) begin
        if (mode == BND_RANGE && atPre) begin
          cntD = cntQ;
        end else if ((mode == BND_MODN && atPre) || atMax) begin
          cntD  = '0;
          carry = 1'b1;
          moved = 1'b1;
          haltD = (mode == BND_ONESHOT);
        end else begin
          cntD  = stepVal;
          moved = 1'b1;
        end
      end else begin
        if (mode == BND_RANGE && atZero) begin
          cntD = cntQ;
        end else if (atZero) begin
          cntD   = (mode == BND_MODN) ? presetQ : maxVal;
          borrow = 1'b1;
          moved  = 1'b1;
          haltD  = (mode == BND_ONESHOT);
        end else begin
          cntD  = stepVal;
          moved = 1'b1;
        end
      end
    end
  end

  assign cmpHit = moved && (cntD == presetQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0; haltQ <= 1'b0; presetQ <= '0; latchQ <= '0;
      evCarry <= 1'b0; evBorrow <= 1'b0; evCmp <= 1'b0;
      btQ <= 1'b0; ctQ <= 1'b0; cptQ <= 1'b0; signQ <= 1'b0;
      errQ <= 1'b0; dirQ <= 1'b0;
    end else begin
      cntQ     <= cntD;
      haltQ    <= haltD;
      evCarry  <= carry;
      evBorrow <= borrow;
      evCmp    <= cmpHit;
      if (presetWr)    presetQ <= presetIn;
      if (stb.doLatch) latchQ  <= cntQ;
      if (stb.dirWr)   dirQ    <= stb.stepUp;
      if (stb.clrFlags) begin
        btQ <= 1'b0; ctQ <= 1'b0; cptQ <= 1'b0; signQ <= 1'b0;
      end else begin
        btQ  <= btQ ^ borrow;
        ctQ  <= ctQ ^ carry;
        cptQ <= cptQ ^ cmpHit;
        if (borrow)     signQ <= 1'b1;
        else if (carry) signQ <= 1'b0;
      end
      if (stb.setErr)      errQ <= 1'b1;
      else if (stb.clrErr) errQ <= 1'b0;
    end
  end

  assign countVal    = cntQ;
  assign latchVal    = latchQ;
  assign statusFlags = {idxSeen, dirQ, errQ, signQ, cptQ, ctQ, btQ};

  always_comb begin
    unique case (flagSel)
      2'd0:    begin flg1 = evCarry;            flg2 = evBorrow; end
      2'd1:    begin flg1 = evCmp;              flg2 = evBorrow; end
      2'd2:    begin flg1 = evCarry | evBorrow; flg2 = dirQ;     end
      default: begin flg1 = idxSeen;            flg2 = errQ;     end
    endcase
  end

  assert_bcd_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doStep && stb.stepUp && !haltQ && bcdMode && mode == BND_FREE && cntQ == BCD_MAX)
    |=> (cntQ == '0 && evCarry));

  assert_range_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doStep && stb.stepUp && mode == BND_RANGE && cntQ == presetQ)
    |=> (cntQ == $past(cntQ) && !evCarry));

  assert_oneshot_halt_R4: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && !stb.doClear && !stb.doLoad) |=> $stable(cntQ));

  assert_sign_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
    evCarry |-> !signQ);

  assert_load_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.doLoad |=> (cntQ == $past(presetQ)));
endmodule

// File: rtl/tally_counter.sv
module tally_counter
  import tally_pkg::*;
#(
  parameter int DIGITS = 6,
  localparam int W = 4 * DIGITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                countStb,
  input  logic                countUp,
  input  logic                bcdMode,
  input  logic [1:0]          bndMode,
  input  logic [1:0]          flagSel,
  input  logic                idxActive,
  input  logic                idxRouteReset,
  input  logic                idxLoadLatch,
  input  logic                idxResetGate,
  input  logic                presetWr,
  input  logic [W-1:0]        presetIn,
  input  logic                cmdLoad,
  input  logic                cmdClear,
  input  logic                cmdLatch,
  input  logic                cmdClrFlags,
  input  logic                cmdClrErr,
  input  logic                errEvent,
  output logic [W-1:0]        countVal,
  output logic [W-1:0]        latchVal,
  output logic [STATUS_W-1:0] statusFlags,
  output logic                flg1,
  output logic                flg2
);
  strobe_t stb;
  logic    idxSeen;

  tally_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .countStb(countStb), .countUp(countUp),
    .idxActive(idxActive), .idxRouteReset(idxRouteReset),
    .idxLoadLatch(idxLoadLatch), .idxResetGate(idxResetGate),
    .cmdLoad(cmdLoad), .cmdClear(cmdClear), .cmdLatch(cmdLatch),
    .cmdClrFlags(cmdClrFlags), .cmdClrErr(cmdClrErr), .errEvent(errEvent),
    .stb(stb), .idxSeen(idxSeen)
  );

  tally_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bcdMode(bcdMode), .bndMode(bndMode),
    .flagSel(flagSel), .presetWr(presetWr), .presetIn(presetIn),
    .idxSeen(idxSeen), .countVal(countVal), .latchVal(latchVal),
    .statusFlags(statusFlags), .flg1(flg1), .flg2(flg2)
  );

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdClear |=> (countVal == '0));

  assert_index_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (idxRouteReset && !idxResetGate && idxActive && !statusFlags[6]) |=> (countVal == '0));
endmodule

// File: tb/sim_tally_counter.sv
module sim_tally_counter;
  localparam int DIGITS = 6;
  localparam int W = 4 * DIGITS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, countStb, countUp, bcdMode, idxActive, idxRouteReset, idxLoadLatch;
  logic idxResetGate, presetWr, cmdLoad, cmdClear, cmdLatch, cmdClrFlags, cmdClrErr, errEvent;
  logic [1:0] bndMode, flagSel;
  logic [W-1:0] presetIn;
  logic [W-1:0] countVal, latchVal;
  logic [6:0] statusFlags;
  logic flg1, flg2;

  tally_counter #(.DIGITS(DIGITS)) u0 (
    .clk(clk), .rstN(rstN), .countStb(countStb), .countUp(countUp), .bcdMode(bcdMode),
    .bndMode(bndMode), .flagSel(flagSel), .idxActive(idxActive),
    .idxRouteReset(idxRouteReset), .idxLoadLatch(idxLoadLatch), .idxResetGate(idxResetGate),
    .presetWr(presetWr), .presetIn(presetIn), .cmdLoad(cmdLoad), .cmdClear(cmdClear),
    .cmdLatch(cmdLatch), .cmdClrFlags(cmdClrFlags), .cmdClrErr(cmdClrErr),
    .errEvent(errEvent), .countVal(countVal), .latchVal(latchVal),
    .statusFlags(statusFlags), .flg1(flg1), .flg2(flg2)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [W-1:0] mCnt, mPre, mLatch;
  logic mHalt, mBt, mCt, mCpt, mSign, mErr, mDir, mIdxPrev, mEvC, mEvB, mEvP;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int toInt(input logic [W-1:0] v, input bit bcd);
    int r = 0;
    if (!bcd) return int'(v);
    for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] fromInt(input int n, input bit bcd);
    logic [W-1:0] r = '0;
    int t = n;
    if (!bcd) return W'(n);
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int maxOf(input bit bcd);
    return bcd ? 999999 : 16777215;
  endfunction

  task automatic modelReset();
    mCnt = '0; mPre = '0; mLatch = '0; mHalt = 0; mBt = 0; mCt = 0; mCpt = 0;
    mSign = 0; mErr = 0; mDir = 0; mIdxPrev = 0; mEvC = 0; mEvB = 0; mEvP = 0;
  endtask

  task automatic modelEdge();
    bit rise, clr, ld, lat, gate, c, b, mv, cmp;
    int val, mx, nv;
    logic [W-1:0] nc;
    rise = idxActive && !mIdxPrev;
    clr  = cmdClear || (rise && idxRouteReset && !idxResetGate);
    ld   = !clr && (cmdLoad || (rise && !idxRouteReset && !idxLoadLatch));
    lat  = cmdLatch || (rise && !idxRouteReset && idxLoadLatch);
    gate = !(idxRouteReset && idxResetGate) || idxActive;
    c = 0; b = 0; mv = 0; nc = mCnt;
    mx = maxOf(bcdMode); val = toInt(mCnt, bcdMode);
    if (clr) begin nc = '0; mHalt = 0; end
    else if (ld) begin nc = mPre; mHalt = 0; end
    else if (countStb && gate && !mHalt) begin
      if (countUp) begin
        if (bndMode == 2'd1 && mCnt == mPre) nc = mCnt;
        else if ((bndMode == 2'd3 && mCnt == mPre) || val == mx) begin
          nc = '0; c = 1; mv = 1; if (bndMode == 2'd2) mHalt = 1;
        end else begin nv = val + 1; nc = fromInt(nv, bcdMode); mv = 1; end
      end else begin
        if (bndMode == 2'd1 && val == 0) nc = mCnt;
        else if (val == 0) begin
          nc = (bndMode == 2'd3) ? mPre : fromInt(mx, bcdMode); b = 1; mv = 1;
          if (bndMode == 2'd2) mHalt = 1;
        end else begin nv = val - 1; nc = fromInt(nv, bcdMode); mv = 1; end
      end
    end
    cmp = mv && (nc == mPre);
    if (lat) mLatch = mCnt;
    mCnt = nc;
    if (presetWr) mPre = presetIn;
    if (countStb) mDir = countUp;
    if (cmdClrFlags) begin mBt = 0; mCt = 0; mCpt = 0; mSign = 0; end
    else begin
      mBt = mBt ^ b; mCt = mCt ^ c; mCpt = mCpt ^ cmp;
      if (b) mSign = 1; else if (c) mSign = 0;
    end
    if (errEvent) mErr = 1; else if (cmdClrErr) mErr = 0;
    mEvC = c; mEvB = b; mEvP = cmp;
    mIdxPrev = idxActive;
  endtask

  task automatic compareAll();
    string tag;
    logic [6:0] st;
    logic e1, e2;
    case (bndMode)
      2'd0: tag = "R2";
      2'd1: tag = "R3";
      2'd2: tag = "R4";
      default: tag = "R5";
    endcase
    st = {mIdxPrev, mDir, mErr, mSign, mCpt, mCt, mBt};
    case (flagSel)
      2'd0: begin e1 = mEvC; e2 = mEvB; end
      2'd1: begin e1 = mEvP; e2 = mEvB; end
      2'd2: begin e1 = mEvC | mEvB; e2 = mDir; end
      default: begin e1 = mIdxPrev; e2 = mErr; end
    endcase
    chk(tag, "count", 32'(countVal), 32'(mCnt));
    chk("R9", "latch", 32'(latchVal), 32'(mLatch));
    chk("R7", "status", 32'(statusFlags), 32'(st));
    chk("R8", "flag pins", {30'b0, flg1, flg2}, {30'b0, e1, e2});
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rstN) modelReset(); else modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    countStb = 0; presetWr = 0; cmdLoad = 0; cmdClear = 0; cmdLatch = 0;
    cmdClrFlags = 0; cmdClrErr = 0; errEvent = 0;
  endtask

  function automatic logic [W-1:0] pickPreset(input bit bcd);
    int mx = maxOf(bcd);
    case ($urandom % 4)
      0: return fromInt(0, bcd);
      1: return fromInt(5, bcd);
      2: return fromInt(mx - 3, bcd);
      default: return fromInt(int'($urandom % (mx + 1)), bcd);
    endcase
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (R1 to R11 run): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rstN = 0; idle(); countUp = 0; bcdMode = 0; bndMode = 0; flagSel = 0;
    idxActive = 0; idxRouteReset = 0; idxLoadLatch = 0; idxResetGate = 0; presetIn = '0;
    modelReset();
    repeat (3) tick();
    rstN = 1;
    // R11 reset state
    chk("R11", "count after reset", 32'(countVal), 0);
    chk("R11", "latch after reset", 32'(latchVal), 0);
    chk("R11", "status after reset", 32'(statusFlags), 0);
    chk("R11", "flags after reset", {30'b0, flg1, flg2}, 0);

    // R1 decimal wrap with carry
    bcdMode = 1; presetIn = 24'h999999; presetWr = 1; tick(); idle();
    cmdLoad = 1; tick(); idle();
    countStb = 1; countUp = 1; tick(); idle();
    chk("R1", "decimal wrap count", 32'(countVal), 0);
    chk("R1", "decimal wrap carry", {31'b0, flg1}, 1);

    // R6 compare event
    bcdMode = 0; presetIn = 24'h000003; presetWr = 1; cmdClear = 1; tick(); idle();
    flagSel = 1;
    for (int i = 0; i < 3; i++) begin countStb = 1; countUp = 1; tick(); idle(); end
    chk("R6", "compare toggle", {31'b0, statusFlags[2]}, 1);
    chk("R6", "compare pin", {31'b0, flg1}, 1);

    // R9 load discards a simultaneous step
    presetIn = 24'h000123; presetWr = 1; tick(); idle();
    cmdLoad = 1; countStb = 1; countUp = 1; tick(); idle();
    chk("R9", "load beats step", 32'(countVal), 32'h123);

    // R10 index clears the counter
    idxRouteReset = 1; idxResetGate = 0; tick();
    idxActive = 1; tick();
    chk("R10", "index clear", 32'(countVal), 0);
    idxActive = 0; idxRouteReset = 0; tick();

    // R4 single pass halts after borrow
    bndMode = 2; cmdClear = 1; tick(); idle();
    for (int i = 0; i < 3; i++) begin countStb = 1; countUp = 0; tick(); idle(); end
    chk("R4", "halted after borrow", 32'(countVal), 32'hFFFFFF);

    // R3 range hold at preset
    bndMode = 1; presetIn = 24'h000002; presetWr = 1; cmdClear = 1; tick(); idle();
    for (int i = 0; i < 4; i++) begin countStb = 1; countUp = 1; tick(); idle(); end
    chk("R3", "held at preset", 32'(countVal), 2);

    // R5 modulo reload on down step at zero
    bndMode = 3; cmdClear = 1; tick(); idle();
    countStb = 1; countUp = 0; tick(); idle();
    chk("R5", "modulo reload", 32'(countVal), 2);

    // constrained random phases
    for (int bcd = 0; bcd < 2; bcd++) begin
      for (int md = 0; md < 4; md++) begin
        bcdMode = bcd[0]; bndMode = md[1:0];
        idxRouteReset = $urandom % 2; idxLoadLatch = $urandom % 2; idxResetGate = $urandom % 2;
        presetIn = pickPreset(bcd[0]); presetWr = 1; cmdClear = 1;
        tick(); idle();
        for (int k = 0; k < 1500; k++) begin
          countStb    = ($urandom % 10) < 7;
          if ($urandom % 10 == 0) countUp = ~countUp;
          cmdLoad     = ($urandom % 100) < 3;
          cmdClear    = ($urandom % 100) < 1;
          cmdLatch    = ($urandom % 100) < 5;
          cmdClrFlags = ($urandom % 100) < 2;
          cmdClrErr   = ($urandom % 100) < 3;
          errEvent    = ($urandom % 100) < 2;
          presetWr    = ($urandom % 100) < 2;
          if (presetWr) presetIn = pickPreset(bcd[0]);
          if ($urandom % 20 == 0) idxActive = ~idxActive;
          flagSel = 2'($urandom % 4);
          tick();
        end
        idle();
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule